// File: doc/BRIEF.md
# Translation Error Classification and Response Unit

This unit sits beside the stream monitors of an address translation agent. Each cycle it takes single-cycle error strobes from the requester-side and completer-side channels and sorts them into classes. For each class it decides three things. The first is whether the unit itself requests an error message toward the host or leaves reporting to the link core. The second is whether the affected header or payload is aborted and discarded. The third is whether the translation in flight ends with a decode-error write response instead of a normal one.

Each channel side has its own handling enable, and stream parity checking has a separate enable. A sticky log keeps the class of the first error seen and an overflow flag for any errors after it. Software clears the log by writing 1. Stream backpressure is a plain combination of the receive-full and downstream-ready conditions, and it never counts as an error.

Top module: `xlat_err_unit`

## Requirements
- R1: A completion-status error (unsupported request, completer abort or unexpected completion, `cpl_err`) with `rq_en` high makes `msg_req` and `discard` pulse in the next cycle and is logged with class code 3.
- R2: A parity error on the completer stream (`par_err_cq`, gated by `cq_en`) or on the requester stream (`par_err_rq`, gated by `rq_en`) is acted on only while `par_chk_en` is high. It then pulses `msg_req`, `abort` and `discard` in the next cycle and is logged with class code 1. While `par_chk_en` is low it has no effect on any output.
- R3: A core-flagged fault (malformed packet, illegal tag, failed completion, `core_err`) with `rq_en` high raises no `msg_req`. It pulses `discard`, is logged with class code 4, and forces a decode error on the write response.
- R4: A requester timeout flagged by the core (`rq_tmo`) changes no output: no message, abort, discard, log entry or decode error.
- R5: A completer timeout (`cq_tmo`) with `cq_en` high pulses `msg_req` and `discard`, is logged with class code 2, and forces a decode error on the write response.
- R6: A poisoned packet or header discontinue (`poison`) pulses `abort` in the next cycle, with no message, no discard, no log entry and no decode error. It does not depend on either enable.
- R7: `s_tready` is high exactly when `rx_full` is low and `dn_ready` is high. Backpressure raises no error output.
- R8: With a channel's enable low, errors belonging to that channel raise no message, discard, abort, log entry or decode error.
- R9: `bresp` is 2'b00 whenever `wr_done` is low. In a cycle with `wr_done` high it is 2'b11 if a decode-forcing error arrived since the last `wr_done` (the current cycle included), and 2'b00 otherwise. Each `wr_done` consumes the pending decode error.
- R10: The log is sticky. The first logged error sets `log_valid` and `log_class`. Any logged error while `log_valid` is high sets `log_ovf` and leaves the class unchanged. `log_clr` clears all three, but an error in the same cycle as the clear is recorded as a new first error.
- R11: When several classes arrive in one cycle, only the highest-priority one is logged, without overflow. The order from highest to lowest is parity, completer timeout, completion status, core fault.
- R12: After reset all pulse outputs and the log are zero, and `bresp` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cq_en | input | 1 | Completer-side error handling enable |
| rq_en | input | 1 | Requester-side error handling enable |
| par_chk_en | input | 1 | Stream parity check enable |
| cpl_err | input | 1 | Completion status error strobe (requester side) |
| par_err_cq | input | 1 | Completer stream parity error strobe |
| par_err_rq | input | 1 | Requester stream parity error strobe |
| core_err | input | 1 | Core-flagged malformed/tag/completion fault strobe |
| rq_tmo | input | 1 | Core-flagged requester timeout strobe |
| cq_tmo | input | 1 | Completer timeout strobe |
| poison | input | 1 | Poisoned packet or header discontinue strobe |
| wr_done | input | 1 | Translation write response is issued this cycle |
| log_clr | input | 1 | Write-1-to-clear of the error log |
| rx_full | input | 1 | Receive store full |
| dn_ready | input | 1 | Downstream ready |
| s_tready | output | 1 | Stream ready |
| msg_req | output | 1 | Error message request pulse |
| abort | output | 1 | Abort strobe for the affected packet |
| discard | output | 1 | Discard strobe for header/payload |
| bresp | output | 2 | Write response code: 2'b11 decode error, 2'b00 okay |
| log_valid | output | 1 | Log holds an error |
| log_class | output | 3 | Class of the first logged error |
| log_ovf | output | 1 | A later error arrived while the log was full |

## Verification
The hardest cases to reach are the ones where several things land in the same cycle. One is a decode-forcing error arriving in the very cycle `wr_done` rises. Another is a log clear coinciding with a new error. A third is several classes arriving together while the log is already occupied. The stimulus steps the unit one cycle at a time with an explicit vector of strobes, so these collisions are placed deliberately. A per-cycle scoreboard then confirms the exact pulse, log and response outcome for each cycle, including the cycle after a collision.

// File: rtl/xlat_err_unit.sv
module xlat_err_unit #(
  parameter int CLS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cq_en,
  input  logic             rq_en,
  input  logic             par_chk_en,
  input  logic             cpl_err,
  input  logic             par_err_cq,
  input  logic             par_err_rq,
  input  logic             core_err,
  input  logic             rq_tmo,
  input  logic             cq_tmo,
  input  logic             poison,
  input  logic             wr_done,
  input  logic             log_clr,
  input  logic             rx_full,
  input  logic             dn_ready,
  output logic             s_tready,
  output logic             msg_req,
  output logic             abort,
  output logic             discard,
  output logic [1:0]       bresp,
  output logic             log_valid,
  output logic [CLS_W-1:0] log_class,
  output logic             log_ovf
);

  localparam logic [CLS_W-1:0] C_NONE = CLS_W'(0);
  localparam logic [CLS_W-1:0] C_PAR  = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_TMO  = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_CPL  = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_CORE = CLS_W'(4);
  localparam logic [1:0] RESP_OK  = 2'b00;
  localparam logic [1:0] RESP_DEC = 2'b11;

  logic h_par, h_cpl, h_core, h_cqto, any_log, dec_now, dec_pend;
  logic [CLS_W-1:0] top_cls;

  // rq_tmo is reported by the core; it is deliberately not acted on here
  assign h_par  = par_chk_en & ((par_err_cq & cq_en) | (par_err_rq & rq_en));
  assign h_cpl  = cpl_err & rq_en;
  assign h_core = core_err & rq_en;
  assign h_cqto = cq_tmo & cq_en;
  assign any_log = h_par | h_cpl | h_core | h_cqto;
  assign dec_now = h_core | h_cqto;

  always_comb begin
    if (h_par)       top_cls = C_PAR;
    else if (h_cqto) top_cls = C_TMO;
    else if (h_cpl)  top_cls = C_CPL;
    else if (h_core) top_cls = C_CORE;
    else             top_cls = C_NONE;
  end

  assign s_tready = ~rx_full & dn_ready;
  assign bresp = (wr_done & (dec_pend | dec_now)) ? RESP_DEC : RESP_OK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_req  <= 1'b0;
      abort    <= 1'b0;
      discard  <= 1'b0;
      dec_pend <= 1'b0;
    end else begin
      msg_req  <= h_par | h_cpl | h_cqto;
      abort    <= h_par | poison;
      discard  <= any_log;
      dec_pend <= wr_done ? 1'b0 : (dec_pend | dec_now);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_valid <= 1'b0;
      log_class <= C_NONE;
      log_ovf   <= 1'b0;
    end else if (log_clr) begin
      log_valid <= any_log;
      log_class <= top_cls;
      log_ovf   <= 1'b0;
    end else if (any_log) begin
      if (!log_valid) begin
        log_valid <= 1'b1;
        log_class <= top_cls;
      end else begin
        log_ovf <= 1'b1;
      end
    end
  end

  a_r1_cpl_report: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_err && rq_en) |=> (msg_req && discard));
  a_r2_par_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_chk_en && !cpl_err && !cq_tmo && !core_err && !poison) |=> (!msg_req && !abort));
  a_r6_poison_abort: assert property (@(posedge clk) disable iff (!rst_n)
    poison |=> abort);
  a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full || !dn_ready) |-> !s_tready);
  a_r8_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cq_en && !rq_en) |=> (!msg_req && !discard));
  a_r9_idle_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done |-> (bresp == RESP_OK));
  a_r9_dec_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && ((core_err && rq_en) || (cq_tmo && cq_en))) |-> (bresp == RESP_DEC));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_clr) |=> (log_valid && $stable(log_class)));

endmodule

// File: tb/sim_xlat_err_unit.sv
`timescale 1ns/1ps
module sim_xlat_err_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cq_en = 1'b0, rq_en = 1'b0, par_chk_en = 1'b0;
  logic cpl_err = 1'b0, par_err_cq = 1'b0, par_err_rq = 1'b0, core_err = 1'b0;
  logic rq_tmo = 1'b0, cq_tmo = 1'b0, poison = 1'b0, wr_done = 1'b0, log_clr = 1'b0;
  logic rx_full = 1'b0, dn_ready = 1'b1;
  logic s_tready, msg_req, abort, discard, log_valid, log_ovf;
  logic [1:0] bresp;
  logic [2:0] log_class;

  always #2 clk = ~clk;

  xlat_err_unit u0 (.*);

  typedef struct {
    logic msg, abt, dsc, v, o;
    logic [2:0] c;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  logic m_v = 0, m_o = 0, m_pend = 0;
  logic [2:0] m_c = 0;
  bit done = 0;

  // ev bits: 0 cpl_err 1 par_cq 2 par_rq 3 core_err 4 rq_tmo 5 cq_tmo 6 poison 7 wr_done 8 log_clr
  task automatic step(input logic [8:0] ev, input string tag);
    logic p, cp, co, ct, has;
    logic [2:0] cls;
    exp_t e;
    @(negedge clk);
    {log_clr, wr_done, poison, cq_tmo, rq_tmo, core_err, par_err_rq, par_err_cq, cpl_err} = ev;
    p  = par_chk_en & ((ev[1] & cq_en) | (ev[2] & rq_en));
    cp = ev[0] & rq_en;
    co = ev[3] & rq_en;
    ct = ev[5] & cq_en;
    has = p | cp | co | ct;
    cls = p ? 3'd1 : ct ? 3'd2 : cp ? 3'd3 : co ? 3'd4 : 3'd0;
    #1;
    checks++;
    if (bresp !== ((ev[7] && (m_pend || co || ct)) ? 2'b11 : 2'b00)) begin
      fails++;
      $display("FAIL %s bresp act=%b exp=%b", tag, bresp, (ev[7] && (m_pend || co || ct)) ? 2'b11 : 2'b00);
    end
    m_pend = ev[7] ? 1'b0 : (m_pend | co | ct);
    if (ev[8]) begin m_v = has; m_c = cls; m_o = 0; end
    else if (has) begin
      if (!m_v) begin m_v = 1; m_c = cls; end else m_o = 1;
    end
    e.msg = p | cp | ct; e.abt = p | ev[6]; e.dsc = has;
    e.v = m_v; e.c = m_c; e.o = m_o; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if ({msg_req, abort, discard, log_valid, log_class, log_ovf} !==
            {e.msg, e.abt, e.dsc, e.v, e.c, e.o}) begin
          fails++;
          $display("FAIL %s msg/abt/dsc/v/cls/ovf act=%b%b%b %b %0d %b exp=%b%b%b %b %0d %b",
            e.tag, msg_req, abort, discard, log_valid, log_class, log_ovf,
            e.msg, e.abt, e.dsc, e.v, e.c, e.o);
        end
      end
    end
  end

  task automatic chk_ready(input logic f, input logic d);
    @(negedge clk);
    rx_full = f; dn_ready = d;
    #1;
    checks++;
    if (s_tready !== (!f && d) || msg_req || abort || discard) begin
      fails++;
      $display("FAIL R7 s_tready act=%b exp=%b", s_tready, !f && d);
    end
  endtask

  task automatic clear_log();
    step(9'h100, "R10_clear");
    step(9'h000, "idle");
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if ({msg_req, abort, discard, log_valid, log_class, log_ovf, bresp} !== 0) begin
      fails++;
      $display("FAIL R12 reset state act=%b exp=0", {msg_req, abort, discard, log_valid, log_class, log_ovf, bresp});
    end
    rst_n = 1'b1;
    cq_en = 1; rq_en = 1; par_chk_en = 1;

    step(9'h001, "R1_cpl");      step(9'h000, "R1_idle");
    step(9'h000, "idle");        clear_log();
    step(9'h002, "R2_par_cq");   step(9'h004, "R10_ovf_par_rq");
    clear_log();
    par_chk_en = 0;
    step(9'h006, "R2_par_off");  step(9'h000, "R2_idle");
    par_chk_en = 1;
    step(9'h008, "R3_core");     step(9'h000, "idle");
    step(9'h080, "R9_dec_after_core");
    step(9'h080, "R9_ok_consumed");
    clear_log();
    step(9'h010, "R4_rq_tmo");   step(9'h080, "R4_no_dec");
    step(9'h020, "R5_cq_tmo");   step(9'h080, "R5_dec");
    clear_log();
    step(9'h0A8, "R9_same_cycle_dec");
    step(9'h080, "R9_ok_after");
    clear_log();
    step(9'h040, "R6_poison");   step(9'h080, "R6_no_dec");
    cq_en = 0; rq_en = 0;
    step(9'h06F, "R8_all_off");  step(9'h080, "R8_no_dec");
    step(9'h040, "R8_R6_poison_ungated");
    cq_en = 1; rq_en = 0;
    step(9'h00D, "R8_rq_off");   step(9'h000, "idle");
    cq_en = 0; rq_en = 1;
    step(9'h022, "R8_cq_off");   step(9'h080, "R8_cq_no_dec");
    cq_en = 1;
    step(9'h029, "R11_cpl_core_tmo");  step(9'h000, "idle");
    clear_log();
    step(9'h009, "R11_cpl_core");      clear_log();
    step(9'h02F, "R11_all");           clear_log();
    step(9'h001, "R10_first");   step(9'h108, "R10_clr_with_new");
    step(9'h000, "R10_idle");    step(9'h020, "R10_ovf");
    step(9'h000, "idle");        step(9'h000, "idle");
    chk_ready(0, 1); chk_ready(1, 1); chk_ready(0, 0); chk_ready(1, 0); chk_ready(0, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule